// File: doc/BRIEF.md
# Data Memory Address Generator

This block works out the data-memory address for a load or store from the instruction's addressing mode. The caller gives it the pointer register value the instruction names (one of the three 16-bit pointers), a full-width direct address, and a small unsigned displacement. It returns the effective address. For the modes that step the pointer, it also returns the new pointer value, which pointer it belongs to, and a write-back enable that the register file uses to store it.

There are five modes: direct, plain pointer, pointer plus displacement, pointer with pre-decrement, and pointer with post-increment. The pointer-plus-displacement mode accepts only the second and third pointers. Any request that breaks the mode rules is flagged as illegal, and it produces no address and no write-back. All pointer arithmetic wraps around the address width. By default the outputs are registered with one cycle of latency. A parameter can select a purely combinational path instead.

Top module: `dmag_top`

## Requirements
- R1: Mode code 0 (direct) gives eff_addr = direct_addr with no write-back, whatever ptr_sel holds.
- R2: Mode code 1 (pointer) gives eff_addr = ptr_val with no write-back.
- R3: Mode code 2 (displacement), with ptr_sel 1 or 2, gives eff_addr = ptr_val + zero-extended disp, modulo 2^ADDR_W, with no write-back. Every disp value from 0 to 63 is accepted.
- R4: Mode code 2 with ptr_sel 0 (the first pointer) raises illegal. eff_addr, wb_en, wb_ptr_sel and wb_value are then all zero.
- R5: Mode code 3 (pre-decrement) gives eff_addr = ptr_val − 1 modulo 2^ADDR_W, and sets wb_en with wb_value equal to that same address.
- R6: Mode code 4 (post-increment) gives eff_addr = ptr_val, and sets wb_en with wb_value = ptr_val + 1 modulo 2^ADDR_W.
- R7: When wb_en is high, wb_ptr_sel equals the request's ptr_sel. When wb_en is low, wb_ptr_sel and wb_value are zero.
- R8: Mode codes 5 to 7, and ptr_sel 3 in any mode other than direct, raise illegal. The address and write-back outputs are then zero.
- R9: out_valid follows req_valid one cycle later. While out_valid is low, every other output is zero.
- R10: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0 to 4 valid) |
| ptr_sel | input | 2 | Pointer tag: 0, 1 or 2; 3 is reserved |
| ptr_val | input | ADDR_W | Current value of the selected pointer |
| direct_addr | input | ADDR_W | Address used by direct mode |
| disp | input | DISP_W | Unsigned displacement |
| out_valid | output | 1 | Result present |
| eff_addr | output | ADDR_W | Effective data address |
| wb_en | output | 1 | Pointer write-back request |
| wb_ptr_sel | output | 2 | Pointer to write back |
| wb_value | output | ADDR_W | New pointer value |
| illegal | output | 1 | Request broke the mode rules |

## Verification
The bench sweeps every mode code against every pointer tag. It uses pointer values at zero, one, and both sides of the sign boundary and the top of the range. This separates correct modulo wrap in pre-decrement and post-increment from saturating or off-by-one arithmetic. Displacements of 0, 1, 31 and 63 show whether the offset is zero-extended and added at full width, and whether the carry out of the low six bits reaches the upper bits. Idle cycles carrying a stepping mode show that an invalid request cannot leak a write-back.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_PTR     = 3'd1,
      AM_DISP    = 3'd2,
      AM_PREDEC  = 3'd3,
      AM_POSTINC = 3'd4
   } am_e;

   localparam logic [1:0] PSEL_FIRST = 2'd0;
   localparam logic [1:0] PSEL_RSVD  = 2'd3;

   typedef struct packed {
      logic sel_direct;
      logic add_disp;
      logic step_down;
      logic step_up;
      logic bad;
   } am_dec_t;
endpackage

// File: rtl/dmag_decode.sv
module dmag_decode
   import dmag_pkg::*;
(
   input  logic [2:0] mode,
   input  logic [1:0] ptr_sel,
   output am_dec_t    dec
);
   logic rsvd_ptr;
   assign rsvd_ptr = (ptr_sel == PSEL_RSVD);

   always_comb begin
      dec = '0;
      case (mode)
         AM_DIRECT:  dec.sel_direct = 1'b1;
         AM_PTR:     dec.bad = rsvd_ptr;
         AM_DISP: begin
            dec.add_disp = 1'b1;
            dec.bad      = rsvd_ptr || (ptr_sel == PSEL_FIRST);
         end
         AM_PREDEC: begin
            dec.step_down = 1'b1;
            dec.bad       = rsvd_ptr;
         end
         AM_POSTINC: begin
            dec.step_up = 1'b1;
            dec.bad     = rsvd_ptr;
         end
         default:    dec.bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/dmag_arith.sv
module dmag_arith
   import dmag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 6
) (
   input  am_dec_t             dec,
   input  logic [ADDR_W-1:0]   ptr_val,
   input  logic [ADDR_W-1:0]   direct_addr,
   input  logic [DISP_W-1:0]   disp,
   output logic [ADDR_W-1:0]   addr,
   output logic                wb,
   output logic [ADDR_W-1:0]   wb_val
);
   localparam int PAD_W = ADDR_W - DISP_W;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] ptr_dn;
   logic [ADDR_W-1:0] ptr_up;
   logic [ADDR_W-1:0] ptr_off;

   assign disp_ext = {{PAD_W{1'b0}}, disp};
   assign ptr_dn   = ptr_val - ONE;
   assign ptr_up   = ptr_val + ONE;
   assign ptr_off  = ptr_val + disp_ext;

   always_comb begin
      addr   = ptr_val;
      wb     = 1'b0;
      wb_val = '0;
      if (dec.sel_direct) begin
         addr = direct_addr;
      end else if (dec.add_disp) begin
         addr = ptr_off;
      end else if (dec.step_down) begin
         addr   = ptr_dn;
         wb     = 1'b1;
         wb_val = ptr_dn;
      end else if (dec.step_up) begin
         wb     = 1'b1;
         wb_val = ptr_up;
      end
   end
endmodule

// File: rtl/dmag_stage.sv
module dmag_stage #(
   parameter int W      = 8,
   parameter bit REG_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG_EN) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
         end
         assign q = q_r;
      end else begin : g_wire
         assign q = rst_n ? d : '0;
      end
   endgenerate
endmodule

// File: rtl/dmag_top.sv
module dmag_top
   import dmag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 6,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        mode,
   input  logic [1:0]        ptr_sel,
   input  logic [ADDR_W-1:0] ptr_val,
   input  logic [ADDR_W-1:0] direct_addr,
   input  logic [DISP_W-1:0] disp,
   output logic              out_valid,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              wb_en,
   output logic [1:0]        wb_ptr_sel,
   output logic [ADDR_W-1:0] wb_value,
   output logic              illegal
);
   localparam int PACK_W = 1 + ADDR_W + 1 + 2 + ADDR_W + 1;

   generate
      if (DISP_W < 1 || DISP_W >= ADDR_W) begin : g_bad_disp
         $error("dmag_top: DISP_W must be between 1 and ADDR_W-1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dmag_top: ADDR_W must be at least 2");
      end
   endgenerate

   am_dec_t           dec;
   logic [ADDR_W-1:0] a_addr;
   logic              a_wb;
   logic [ADDR_W-1:0] a_wbv;
   logic              keep;
   logic [PACK_W-1:0] nxt;
   logic [PACK_W-1:0] cur;

   dmag_decode i_dec (
      .mode    (mode),
      .ptr_sel (ptr_sel),
      .dec     (dec)
   );

   dmag_arith #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_arith (
      .dec         (dec),
      .ptr_val     (ptr_val),
      .direct_addr (direct_addr),
      .disp        (disp),
      .addr        (a_addr),
      .wb          (a_wb),
      .wb_val      (a_wbv)
   );

   assign keep = req_valid && !dec.bad;
   assign nxt  = {req_valid,
                  keep ? a_addr : {ADDR_W{1'b0}},
                  keep && a_wb,
                  (keep && a_wb) ? ptr_sel : 2'd0,
                  (keep && a_wb) ? a_wbv : {ADDR_W{1'b0}},
                  req_valid && dec.bad};

   dmag_stage #(.W(PACK_W), .REG_EN(REG_OUT)) i_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (cur)
   );

   assign {out_valid, eff_addr, wb_en, wb_ptr_sel, wb_value, illegal} = cur;
endmodule

// File: rtl/dmag_chk.sv
module dmag_chk #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 6,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        mode,
   input  logic [1:0]        ptr_sel,
   input  logic [ADDR_W-1:0] ptr_val,
   input  logic [ADDR_W-1:0] direct_addr,
   input  logic [DISP_W-1:0] disp,
   input  logic              out_valid,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              wb_en,
   input  logic [1:0]        wb_ptr_sel,
   input  logic [ADDR_W-1:0] wb_value,
   input  logic              illegal
);
   logic              v_s;
   logic [2:0]        m_s;
   logic [1:0]        s_s;
   logic [ADDR_W-1:0] p_s;
   logic [ADDR_W-1:0] d_s;
   logic [DISP_W-1:0] o_s;

   generate
      if (REG_OUT) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_s <= 1'b0; m_s <= '0; s_s <= '0;
               p_s <= '0;   d_s <= '0; o_s <= '0;
            end else begin
               v_s <= req_valid; m_s <= mode;        s_s <= ptr_sel;
               p_s <= ptr_val;   d_s <= direct_addr; o_s <= disp;
            end
         end
      end else begin : g_live
         assign v_s = req_valid; assign m_s = mode;        assign s_s = ptr_sel;
         assign p_s = ptr_val;   assign d_s = direct_addr; assign o_s = disp;
      end
   endgenerate

   logic ok_ptr;
   assign ok_ptr = (s_s != 2'd3);

   // R1
   direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && m_s == 3'd0) |-> (eff_addr == d_s && !wb_en && !illegal));
   // R2
   ptr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && m_s == 3'd1 && ok_ptr) |-> (eff_addr == p_s && !wb_en && !illegal));
   // R3
   disp_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && m_s == 3'd2 && ok_ptr && s_s != 2'd0) |->
      (ADDR_W'(eff_addr - p_s) == ADDR_W'(o_s) && !wb_en && !illegal));
   // R4
   disp_first_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && m_s == 3'd2 && s_s == 2'd0) |-> (illegal && !wb_en && eff_addr == '0));
   // R5
   predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && m_s == 3'd3 && ok_ptr) |->
      (wb_en && wb_value == eff_addr && ADDR_W'(eff_addr + 1'b1) == p_s));
   // R6
   postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && m_s == 3'd4 && ok_ptr) |->
      (wb_en && eff_addr == p_s && ADDR_W'(wb_value - eff_addr) == ADDR_W'(1)));
   // R7
   wb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_ptr_sel == s_s));
   // R7
   wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_en |-> (wb_ptr_sel == 2'd0 && wb_value == '0));
   // R8
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_s && (m_s > 3'd4 || (m_s != 3'd0 && !ok_ptr))) |->
      (illegal && !wb_en && eff_addr == '0));
   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_s);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!wb_en && !illegal && eff_addr == '0));
endmodule

bind dmag_top dmag_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .REG_OUT(REG_OUT)) i_dmag_chk (.*);

// File: tb/test_dmag_top.sv
module test_dmag_top;
   localparam int AW = 16;
   localparam int DW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    mode = '0;
   logic [1:0]    ptr_sel = '0;
   logic [AW-1:0] ptr_val = '0;
   logic [AW-1:0] direct_addr = '0;
   logic [DW-1:0] disp = '0;
   logic          out_valid;
   logic [AW-1:0] eff_addr;
   logic          wb_en;
   logic [1:0]    wb_ptr_sel;
   logic [AW-1:0] wb_value;
   logic          illegal;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dmag_top #(.ADDR_W(AW), .DISP_W(DW), .REG_OUT(1'b1)) i_dmag_top (.*);

   function automatic logic [AW-1:0] ptr_pick(int k);
      case (k)
         0: return 16'h0000; 1: return 16'h0001; 2: return 16'h0002;
         3: return 16'h7FFF; 4: return 16'h8000; 5: return 16'hFFC0;
         6: return 16'hFFFE; default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic [DW-1:0] disp_pick(int k);
      case (k)
         0: return 6'd0; 1: return 6'd1; 2: return 6'd31; default: return 6'd63;
      endcase
   endfunction

   task automatic compare(string tag, logic [AW*2+5:0] got, logic [AW*2+5:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got v=%0b a=%h wb=%0b s=%0d w=%h ill=%0b  exp v=%0b a=%h wb=%0b s=%0d w=%h ill=%0b",
                  tag, got[2*AW+5], got[2*AW+4:AW+5], got[AW+4], got[AW+3:AW+2], got[AW+1:1], got[0],
                  exp[2*AW+5], exp[2*AW+4:AW+5], exp[AW+4], exp[AW+3:AW+2], exp[AW+1:1], exp[0]);
      end
   endtask

   function automatic logic [AW*2+5:0] outs();
      return {out_valid, eff_addr, wb_en, wb_ptr_sel, wb_value, illegal};
   endfunction

   task automatic run_one(logic v, logic [2:0] m, logic [1:0] s,
                          logic [AW-1:0] p, logic [AW-1:0] d, logic [DW-1:0] o);
      logic [AW-1:0] ea, wv;
      logic we, bad;
      string tag;
      ea = '0; wv = '0; we = 1'b0; bad = 1'b0;
      case (m)
         3'd0: begin ea = d; tag = "R1"; end
         3'd1: begin bad = (s == 2'd3); ea = p; tag = "R2"; end
         3'd2: begin
            bad = (s == 2'd3) || (s == 2'd0);
            ea  = p + {10'd0, o};
            tag = (s == 2'd0) ? "R4" : "R3";
         end
         3'd3: begin bad = (s == 2'd3); ea = p - 16'd1; we = 1'b1; wv = p - 16'd1; tag = "R5/R7"; end
         3'd4: begin bad = (s == 2'd3); ea = p; we = 1'b1; wv = p + 16'd1; tag = "R6/R7"; end
         default: begin bad = 1'b1; tag = "R8"; end
      endcase
      if (bad && m != 3'd2) tag = "R8";
      if (bad) begin ea = '0; we = 1'b0; wv = '0; end
      if (!v) begin ea = '0; we = 1'b0; wv = '0; bad = 1'b0; tag = "R9"; end
      @(negedge clk);
      req_valid = v; mode = m; ptr_sel = s; ptr_val = p; direct_addr = d; disp = o;
      @(posedge clk);
      @(negedge clk);
      compare(tag, outs(), {v, ea, we, we ? s : 2'd0, wv, v && bad});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R10: reset holds outputs at zero even with a live request
      req_valid = 1'b1; mode = 3'd4; ptr_sel = 2'd1; ptr_val = 16'h1234;
      @(posedge clk); @(negedge clk);
      compare("R10", outs(), '0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10", outs(), '0);

      for (int m = 0; m < 8; m++)
         for (int s = 0; s < 4; s++)
            for (int pk = 0; pk < 8; pk++)
               for (int dk = 0; dk < 4; dk++) begin
                  run_one(1'b1, 3'(m), 2'(s), ptr_pick(pk),
                          ptr_pick(pk) ^ 16'hA5C3, disp_pick(dk));
                  // R9: idle cycle carrying a stepping request yields nothing
                  if (dk == 3)
                     run_one(1'b0, 3'd3, 2'(s), ptr_pick(pk), 16'h0F0F, disp_pick(dk));
               end

      // R3: every displacement value at a carrying base
      for (int o = 0; o < 64; o++)
         run_one(1'b1, 3'd2, 2'd2, 16'h00F0, 16'h0, 6'(o));

      // R1: direct mode ignores reserved pointer tag
      run_one(1'b1, 3'd0, 2'd3, 16'hFFFF, 16'hBEEF, 6'd5);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule